// File: doc/BRIEF.md
# ATM Cell Transmit Link Controller

This block is the link-layer end of an 8-bit cell transmit path toward a physical-layer device. A user-side buffer holds complete cells as 27 words of 16 bits and announces that a cell is waiting with a level ready flag. The controller fetches the words through an addressed read port, splits each word into two bytes, and drives the byte bus, the active-low transmit enable and the start-of-cell marker toward the PHY.

A cell starts only when the PHY reports room for a cell and the user side has one ready. Once started, the cell goes out in full on consecutive clocks. At the end of a cell, the controller either starts the next cell on the very next clock or releases the enable and waits. A mode input selects the 54-byte format, which sends everything in the buffer, or the 53-byte format, which leaves out the sixth byte of the stored cell.

Top module: `atm_tx_link`

## Requirements
- R1: While `rst` is high and after its release with nothing to send, `phy_txen_n` is 1, `phy_soc` is 0 and `usr_rd_en` is 0.
- R2: No cell starts and no word is read unless `phy_space` and `usr_ready` are both high. The first byte of a cell is on the bus two rising edges after the first edge at which both are high.
- R3: Each cell causes exactly 27 reads. Their `usr_rd_idx` values are 0, 1, 2 … 26, in that order. Read data is taken one clock after `usr_rd_en`.
- R4: With `cell_size54`=1, all 54 bytes of a cell are sent. Byte 2k is bits [15:8] of word k and byte 2k+1 is bits [7:0] of word k.
- R5: With `cell_size54`=0, 53 bytes are sent. The stored byte at position 5 (bits [7:0] of word 2) is skipped, and the other bytes keep their order.
- R6: `phy_soc` is 1 on the first byte of each cell and 0 on every other clock.
- R7: `phy_txen_n` is 0 exactly on the clocks that carry a cell byte, with no gap inside a cell. It returns to 1 after the last byte when no cell follows.
- R8: If `phy_space` and `usr_ready` are high while the last byte of a cell is being loaded, the first byte of the next cell follows on the next clock.
- R9: A started cell is completed even if `phy_space` falls during it. No next cell starts while `phy_space` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Active-high synchronous reset |
| cell_size54 | input | 1 | 1 selects 54-byte cells, 0 selects 53-byte cells |
| phy_space | input | 1 | PHY can accept a whole cell |
| phy_txen_n | output | 1 | Active-low: a valid byte is on `phy_data` |
| phy_soc | output | 1 | High on the first byte of a cell |
| phy_data | output | 8 | Byte toward the PHY |
| usr_ready | input | 1 | User buffer holds a cell to send |
| usr_rd_en | output | 1 | Read strobe toward the user buffer |
| usr_rd_idx | output | 5 | Word index of the read, 0 to 26 |
| usr_rd_data | input | 16 | Word returned one clock after the read |

## Verification
The read strobe is combinational in the cycle it is issued, and the user model returns the word at the next edge. The byte built from that word reaches the PHY pins one edge later, so the first byte of a cell is on the bus two edges after the edge at which both ready inputs were first seen high. The bench drives inputs and samples outputs on falling edges and checks the start latency at exactly those two falling edges. Byte streams are recorded with a falling-edge cycle stamp, so gaps and back-to-back joins are judged by consecutive stamps and not by waiting a loose number of clocks.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

  // Position of the next stored byte to load, jumping over the skipped one
  // when the short cell format is active.
  function automatic int unsigned step_pos(input int unsigned cur,
                                           input logic full_cell,
                                           input int unsigned skip);
    if (!full_cell && (cur + 1 == skip))
      return cur + 2;
    return cur + 1;
  endfunction

  // Word that holds a stored byte position.
  function automatic int unsigned word_of(input int unsigned bpos);
    return bpos / 2;
  endfunction

  // Even positions take the upper half of a word.
  function automatic logic upper_half(input int unsigned bpos);
    return (bpos % 2) == 0;
  endfunction

endpackage

// File: rtl/atm_tx_seq.sv
module atm_tx_seq #(
  parameter int CELL_BYTES = 54,
  parameter int SKIP_POS   = 5,
  parameter int IDX_W      = 5,
  parameter int POS_W      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_cell,
  input  logic             phy_space,
  input  logic             usr_ready,
  output logic             active,
  output logic [POS_W-1:0] pos,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             last_load,
  output logic             cell_go
);
  import atm_tx_pkg::*;

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  logic [POS_W-1:0] nxt_pos;
  logic             at_boundary;

  always_comb begin
    last_load   = active && (pos == LAST_POS);
    at_boundary = !active || last_load;
    cell_go     = at_boundary && phy_space && usr_ready;
    nxt_pos     = POS_W'(step_pos(int'(pos), full_cell, SKIP_POS));
    if (at_boundary) begin
      rd_en  = cell_go;
      rd_idx = '0;
    end else begin
      rd_en  = upper_half(int'(nxt_pos));
      rd_idx = IDX_W'(word_of(int'(nxt_pos)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (at_boundary) begin
      active <= cell_go;
      pos    <= '0;
    end else begin
      pos <= nxt_pos;
    end
  end

endmodule

// File: rtl/atm_tx_ser.sv
module atm_tx_ser #(
  parameter int BYTE_W = 8,
  parameter int POS_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic [POS_W-1:0]    pos,
  input  logic [2*BYTE_W-1:0] word_in,
  output logic                txen_n,
  output logic                soc,
  output logic [BYTE_W-1:0]   data
);
  import atm_tx_pkg::*;

  logic [BYTE_W-1:0] low_hold;
  logic              take_upper;

  assign take_upper = upper_half(int'(pos));

  always_ff @(posedge clk) begin
    if (rst) begin
      txen_n   <= 1'b1;
      soc      <= 1'b0;
      data     <= '0;
      low_hold <= '0;
    end else if (active) begin
      txen_n <= 1'b0;
      soc    <= (pos == '0);
      if (take_upper) begin
        data     <= word_in[2*BYTE_W-1:BYTE_W];
        low_hold <= word_in[BYTE_W-1:0];
      end else begin
        data <= low_hold;
      end
    end else begin
      txen_n <= 1'b1;
      soc    <= 1'b0;
    end
  end

endmodule

// File: rtl/atm_tx_link.sv
module atm_tx_link #(
  parameter int CELL_BYTES = 54,
  parameter int SKIP_POS   = 5,
  parameter int BYTE_W     = 8,
  parameter int IDX_W      = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_size54,
  input  logic                phy_space,
  output logic                phy_txen_n,
  output logic                phy_soc,
  output logic [BYTE_W-1:0]   phy_data,
  input  logic                usr_ready,
  output logic                usr_rd_en,
  output logic [IDX_W-1:0]    usr_rd_idx,
  input  logic [2*BYTE_W-1:0] usr_rd_data
);
  localparam int POS_W = $clog2(CELL_BYTES);

  logic             seq_active;
  logic [POS_W-1:0] seq_pos;
  logic             last_load;
  logic             cell_go;

  atm_tx_seq #(
    .CELL_BYTES(CELL_BYTES),
    .SKIP_POS  (SKIP_POS),
    .IDX_W     (IDX_W),
    .POS_W     (POS_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .full_cell(cell_size54),
    .phy_space(phy_space),
    .usr_ready(usr_ready),
    .active   (seq_active),
    .pos      (seq_pos),
    .rd_en    (usr_rd_en),
    .rd_idx   (usr_rd_idx),
    .last_load(last_load),
    .cell_go  (cell_go)
  );

  atm_tx_ser #(
    .BYTE_W(BYTE_W),
    .POS_W (POS_W)
  ) u_ser (
    .clk    (clk),
    .rst    (rst),
    .active (seq_active),
    .pos    (seq_pos),
    .word_in(usr_rd_data),
    .txen_n (phy_txen_n),
    .soc    (phy_soc),
    .data   (phy_data)
  );

endmodule

// File: rtl/atm_tx_chk.sv
module atm_tx_chk #(
  parameter int IDX_W     = 5,
  parameter int LAST_WORD = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             phy_space,
  input logic             usr_ready,
  input logic             phy_txen_n,
  input logic             phy_soc,
  input logic             usr_rd_en,
  input logic [IDX_W-1:0] usr_rd_idx,
  input logic             last_load,
  input logic             cell_go
);

  // R6
  soc_with_enable_chk: assert property (@(posedge clk) disable iff (rst)
    phy_soc |-> !phy_txen_n);

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    usr_rd_en |-> (usr_rd_idx <= IDX_W'(LAST_WORD)));

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (usr_rd_en && usr_rd_idx == '0) |-> (phy_space && usr_ready));

  // R6
  soc_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    cell_go |=> ##1 phy_soc);

  // R7
  release_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_txen_n) |-> $past(last_load, 2));

endmodule

bind atm_tx_link atm_tx_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phy_space (phy_space),
  .usr_ready (usr_ready),
  .phy_txen_n(phy_txen_n),
  .phy_soc   (phy_soc),
  .usr_rd_en (usr_rd_en),
  .usr_rd_idx(usr_rd_idx),
  .last_load (last_load),
  .cell_go   (cell_go)
);

// File: tb/test_atm_tx_link.sv
module test_atm_tx_link;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_size54 = 1'b1;
  logic        phy_space = 1'b0;
  logic        phy_txen_n;
  logic        phy_soc;
  logic [7:0]  phy_data;
  logic        usr_ready;
  logic        usr_rd_en;
  logic [4:0]  usr_rd_idx;
  logic [15:0] usr_rd_data = '0;

  atm_tx_link i_atm_tx_link (
    .clk        (clk),
    .rst        (rst),
    .cell_size54(cell_size54),
    .phy_space  (phy_space),
    .phy_txen_n (phy_txen_n),
    .phy_soc    (phy_soc),
    .phy_data   (phy_data),
    .usr_ready  (usr_ready),
    .usr_rd_en  (usr_rd_en),
    .usr_rd_idx (usr_rd_idx),
    .usr_rd_data(usr_rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Stored word pattern: upper = {id, idx}, lower = {~id, idx}.
  function automatic logic [15:0] word_val(input int id, input int idx);
    logic [2:0] c;
    c = id[2:0];
    return {c, idx[4:0], ~c, idx[4:0]};
  endfunction

  function automatic logic [7:0] exp_byte(input int id, input int k, input bit full);
    int u;
    logic [15:0] w;
    u = (!full && k >= 5) ? k + 1 : k;
    w = word_val(id, u / 2);
    return (u % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  // User buffer model: synchronous read, cell count granted by the tasks.
  int granted = 0;
  int next_id = 0;
  int cur_id = 0;
  int rd_count = 0;
  int seq_err = 0;
  int last_idx = 0;
  assign usr_ready = (granted != next_id);

  always @(posedge clk) begin
    if (!rst && usr_rd_en) begin
      rd_count <= rd_count + 1;
      if (usr_rd_idx == 5'd0) begin
        cur_id      <= next_id;
        next_id     <= next_id + 1;
        usr_rd_data <= word_val(next_id, 0);
      end else begin
        usr_rd_data <= word_val(cur_id, int'(usr_rd_idx));
        if (int'(usr_rd_idx) != last_idx + 1) seq_err <= seq_err + 1;
      end
      last_idx <= int'(usr_rd_idx);
    end
  end

  // PHY-side monitor, stamped on falling edges.
  logic [7:0] mon_data [2048];
  bit         mon_soc  [2048];
  int         mon_cyc  [2048];
  int         nbytes = 0;
  int         cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && !phy_txen_n && nbytes < 2048) begin
      mon_data[nbytes] = phy_data;
      mon_soc[nbytes]  = phy_soc;
      mon_cyc[nbytes]  = cyc;
      nbytes++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_stream(input int base, input int ncells, input bit full,
                              input int id0, input string req);
    int len, bad_data, bad_soc, gaps, first_bad, fb_act, fb_exp;
    len = full ? 54 : 53;
    bad_data = 0; bad_soc = 0; gaps = 0; first_bad = -1; fb_act = 0; fb_exp = 0;
    chk(nbytes - base == ncells * len, req, "byte count", nbytes - base, ncells * len);
    for (int k = 0; k < ncells * len && base + k < nbytes; k++) begin
      logic [7:0] e;
      e = exp_byte(id0 + k / len, k % len, full);
      if (mon_data[base + k] != e) begin
        if (first_bad < 0) begin first_bad = k; fb_act = mon_data[base + k]; fb_exp = e; end
        bad_data++;
      end
      if (mon_soc[base + k] != (k % len == 0)) bad_soc++;
      if (k > 0 && mon_cyc[base + k] != mon_cyc[base + k - 1] + 1) gaps++;
    end
    chk(bad_data == 0, req, "byte content (first bad value)", fb_act, fb_exp);
    chk(bad_soc == 0, "R6", "start-of-cell misplacements", bad_soc, 0);
    chk(gaps == 0, "R7", "gaps inside stream", gaps, 0);
    chk(phy_txen_n == 1'b1, "R7", "enable released after last cell", phy_txen_n, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    wait_cyc(4);
    chk(phy_txen_n == 1'b1 && phy_soc == 1'b0 && usr_rd_en == 1'b0, "R1",
        "outputs in reset {txen_n,soc,rd_en}", {phy_txen_n, phy_soc, usr_rd_en}, 3'b100);
    rst = 1'b0;
    wait_cyc(3);
    chk(phy_txen_n == 1'b1 && phy_soc == 1'b0 && usr_rd_en == 1'b0, "R1",
        "idle after reset {txen_n,soc,rd_en}", {phy_txen_n, phy_soc, usr_rd_en}, 3'b100);
  endtask

  task automatic t_single(input bit full, input string req);
    int base, rbase, id0, sbase;
    base = nbytes; rbase = rd_count; id0 = next_id; sbase = seq_err;
    cell_size54 = full;
    phy_space = 1'b1;
    granted = granted + 1;
    wait_cyc(90);
    check_stream(base, 1, full, id0, req);
    chk(rd_count - rbase == 27, "R3", "reads per cell", rd_count - rbase, 27);
    chk(seq_err == sbase, "R3", "out-of-order read indices", seq_err - sbase, 0);
  endtask

  task automatic t_b2b(input bit full);
    int base, rbase, id0, len;
    base = nbytes; rbase = rd_count; id0 = next_id;
    len = full ? 54 : 53;
    cell_size54 = full;
    phy_space = 1'b1;
    granted = granted + 3;
    wait_cyc(210);
    check_stream(base, 3, full, id0, "R8");
    chk(mon_cyc[base + len] == mon_cyc[base + len - 1] + 1, "R8",
        "next cell joins on next clock", mon_cyc[base + len] - mon_cyc[base + len - 1], 1);
    chk(rd_count - rbase == 81, "R3", "reads for three cells", rd_count - rbase, 81);
  endtask

  task automatic t_gate();
    int rbase, id0;
    cell_size54 = 1'b1;
    // Ready but no PHY space.
    phy_space = 1'b0;
    rbase = rd_count;
    granted = granted + 1;
    wait_cyc(20);
    chk(rd_count == rbase && phy_txen_n == 1'b1, "R2", "no start without PHY space",
        rd_count - rbase, 0);
    // PHY space but user not ready.
    granted = granted - 1;
    phy_space = 1'b1;
    wait_cyc(20);
    chk(rd_count == rbase && phy_txen_n == 1'b1, "R2", "no start without user cell",
        rd_count - rbase, 0);
    // Start latency.
    phy_space = 1'b0;
    granted = granted + 1;
    id0 = next_id;
    @(negedge clk);
    phy_space = 1'b1;
    @(negedge clk);
    chk(phy_txen_n == 1'b1, "R2", "txen_n one edge after go", phy_txen_n, 1);
    @(negedge clk);
    chk(phy_txen_n == 1'b0 && phy_soc == 1'b1, "R2", "first byte two edges after go",
        {phy_txen_n, phy_soc}, 2'b01);
    chk(phy_data == exp_byte(id0, 0, 1'b1), "R4", "first header byte", phy_data,
        exp_byte(id0, 0, 1'b1));
    wait_cyc(80);
  endtask

  task automatic t_drop();
    int base, rbase, id0;
    base = nbytes; rbase = rd_count; id0 = next_id;
    cell_size54 = 1'b1;
    phy_space = 1'b1;
    granted = granted + 2;
    while (!(phy_txen_n == 1'b0 && phy_soc == 1'b1)) @(negedge clk);
    phy_space = 1'b0;
    wait_cyc(100);
    check_stream(base, 1, 1'b1, id0, "R9");
    chk(rd_count - rbase == 27, "R9", "no second cell while space low", rd_count - rbase, 27);
    phy_space = 1'b1;
    wait_cyc(90);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single(1'b1, "R4");
    t_single(1'b0, "R5");
    t_b2b(1'b1);
    t_b2b(1'b0);
    t_gate();
    t_drop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule